// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block keeps the per-source interrupt state for a fixed group of sources and decides, for each processor, whether an interrupt request should be raised. Software reaches it through a word-addressed 32-bit register port. Writes take effect on the clock edge. Reads are combinational from the address. Each source has an input line. The block holds an enable bit, a per-processor pending vector, an active flag, a priority byte, a processor-target byte and a two-bit trigger/model field for every source.

A processor-side interface tells the block when a processor takes an interrupt (acknowledge) and when it finishes one (end of interrupt). Acknowledge makes the source active and removes pending state according to the source's model. End of interrupt clears the active flag. A software-generated-interrupt word lets software raise one of the low sixteen sources on a chosen set of processors. A global gate decides whether anything reaches the processors at all.

Top module: `irq_distributor`

## Requirements
- R1: After reset, the global gate, every enable, pending, active, priority, target and config field is 0, and `cpu_irq` is 0.
- R2: Word 0x00 bit 0 is the global gate. While it is 0, `cpu_irq` is all zero from the next clock on. It is readable at the same word.
- R3: Words 0x04+k (set) and 0x08+k (clear) act on the enables of sources 32k..32k+31, bit i for source 32k+i. A 1 bit sets or clears that enable and a 0 bit changes nothing. Either word reads back the current enables.
- R4: Words 0x0C+k (set) and 0x10+k (clear) use the same bit layout. A set bit adds the source's target processors to its pending vector. A clear bit empties the pending vector. Either word reads 1 for each source that is pending for any processor.
- R5: Priority bytes sit at word 0x20+s/4 and target bytes at word 0x40+s/4, in byte s%4 (bits 8*(s%4)+7 down to 8*(s%4)). Both read back as written. Target bit c names processor c.
- R6: The config field of source s sits at word 0x60+s/16. Bit 2*(s%16)+1 selects edge (1) or level (0). Bit 2*(s%16) selects the one-of-N model (1) or the per-processor model (0). The field reads back as written.
- R7: An edge-configured source becomes pending for its targets on a rising edge of its input. An input held high does not raise it again after its pending state is cleared.
- R8: A level-configured source is pending for its targets while its input is high and it is not active. It stops being pending when the input falls.
- R9: `cpu_irq[c]` is 1 one clock after the gate is 1 and some source is enabled, not active and pending for processor c. Otherwise it is 0.
- R10: An acknowledge (`ack_valid`, `ack_id`, `ack_cpu`) makes the source active. Under the one-of-N model it empties the source's whole pending vector. Under the per-processor model it clears only bit `ack_cpu`.
- R11: An end of interrupt (`eoi_valid`, `eoi_id`) clears the source's active flag, so pending state left behind is forwarded again.
- R12: Word 0x68+s/16 reports source s in bits 2*(s%16)+1 down to 2*(s%16). The code is 0 for inactive, 1 for pending, 2 for active and 3 for pending and active.
- R13: A write to word 0x18 raises the source in bits 3:0 (sources 0..15) as pending. The processors are picked by the filter in bits 25:24. Filter 0 uses the list in bits 23:16. Filter 1 picks every processor except `sgi_req_cpu`. Filter 2 picks only `sgi_req_cpu`. Filter 3 picks none.
- R14: Word 0x01 reads a constant: bits 7:5 hold the processor count minus 1, and bits 4:0 hold the source count divided by 32, minus 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register word address |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| src_in | input | NUM_SRC | Source input lines |
| sgi_req_cpu | input | log2(NUM_CPU) | Processor issuing a software-generated write |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_cpu | input | log2(NUM_CPU) | Acknowledging processor |
| ack_id | input | log2(NUM_SRC) | Acknowledged source |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_id | input | log2(NUM_SRC) | Source whose handling ended |
| cpu_irq | output | NUM_CPU | Interrupt request per processor |

## Verification
A wrong pending vector shows up on `cpu_irq` one clock after it is stored. It also shows up combinationally on the pending and state words. A stuck or missed active flag shows as the wrong two-bit state code at once. One clock later it shows as a request that should have been masked, or unmasked after end of interrupt. Model errors are split apart by acknowledging a source that targets two processors and checking which processor's request survives the following end of interrupt. Filter errors in software-generated writes appear as the wrong processor pattern on `cpu_irq`.

// File: rtl/idist_pkg.sv
package idist_pkg;
   localparam int TGT_W   = 8;
   localparam int PRIO_W  = 8;
   localparam int SGI_IDS = 16;
   localparam int MIN_AW  = 7;

   // word addresses
   localparam int A_CTRL  = 'h00;
   localparam int A_INFO  = 'h01;
   localparam int A_SETEN = 'h04;
   localparam int A_CLREN = 'h08;
   localparam int A_SETPD = 'h0C;
   localparam int A_CLRPD = 'h10;
   localparam int A_ACT   = 'h14;
   localparam int A_SGI   = 'h18;
   localparam int A_PRIO  = 'h20;
   localparam int A_TGT   = 'h40;
   localparam int A_CFG   = 'h60;
   localparam int A_STATE = 'h68;

   typedef enum logic [1:0] {
      SGI_LIST   = 2'd0,
      SGI_OTHERS = 2'd1,
      SGI_SELF   = 2'd2,
      SGI_NONE   = 2'd3
   } sgi_filter_e;

   typedef struct packed {
      logic edge_trig;
      logic one_of_n;
   } src_cfg_t;
endpackage

// File: rtl/idist_sgi_resolve.sv
module idist_sgi_resolve
   import idist_pkg::*;
#(
   parameter int NUM_CPU = 8,
   localparam int CPU_W  = $clog2(NUM_CPU)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_CPU-1:0] list,
   input  logic [1:0]         filter,
   input  logic [CPU_W-1:0]   req_cpu,
   output logic [NUM_CPU-1:0] mask
);
   sgi_filter_e flt;
   assign flt = sgi_filter_e'(filter);

   always_comb begin
      mask = '0;
      case (flt)
         SGI_LIST:   mask = list;
         SGI_OTHERS: begin
            mask = '1;
            mask[req_cpu] = 1'b0;
         end
         SGI_SELF:   mask[req_cpu] = 1'b1;
         default:    mask = '0;
      endcase
   end

   // R13: self-only filter picks exactly one processor
   a_r13_self_single: assert property (@(posedge clk) disable iff (!rst_n)
      (flt == SGI_SELF) |-> ($countones(mask) == 1));
   // R13: others filter never picks the requester
   a_r13_others_excl: assert property (@(posedge clk) disable iff (!rst_n)
      (flt == SGI_OTHERS) |-> !mask[req_cpu]);
endmodule

// File: rtl/idist_src_cell.sv
module idist_src_cell
   import idist_pkg::*;
#(
   parameter int NUM_CPU = 8,
   localparam int CPU_W  = $clog2(NUM_CPU)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               src_in,
   input  logic               wr_set_en,
   input  logic               wr_clr_en,
   input  logic               wr_set_pd,
   input  logic               wr_clr_pd,
   input  logic               wr_prio,
   input  logic               wr_tgt,
   input  logic               wr_cfg,
   input  logic [7:0]         wbyte,
   input  logic [1:0]         wcfg,
   input  logic               sgi_hit,
   input  logic [NUM_CPU-1:0] sgi_mask,
   input  logic               ack_hit,
   input  logic [CPU_W-1:0]   ack_cpu,
   input  logic               eoi_hit,
   output logic               en,
   output logic               pending,
   output logic               active,
   output logic [PRIO_W-1:0]  prio,
   output logic [TGT_W-1:0]   tgt,
   output src_cfg_t           cfg,
   output logic [NUM_CPU-1:0] fwd
);
   logic               en_q, act_q, src_q, edge_evt;
   logic [PRIO_W-1:0]  prio_q;
   logic [TGT_W-1:0]   tgt_q;
   src_cfg_t           cfg_q;
   logic [NUM_CPU-1:0] pm_q, pm_set, pm_clr, lvl_vec, pend_vec, tgt_cpu;

   assign tgt_cpu  = tgt_q[NUM_CPU-1:0];
   assign edge_evt = cfg_q.edge_trig & src_in & ~src_q;

   always_comb begin
      pm_set = '0;
      if (wr_set_pd || edge_evt) pm_set |= tgt_cpu;
      if (sgi_hit)               pm_set |= sgi_mask;
      pm_clr = '0;
      if (wr_clr_pd) pm_clr = '1;
      if (ack_hit) begin
         if (cfg_q.one_of_n) pm_clr = '1;
         else                pm_clr[ack_cpu] = 1'b1;
      end
   end

   assign lvl_vec  = (!cfg_q.edge_trig && src_in && !act_q) ? tgt_cpu : '0;
   assign pend_vec = pm_q | lvl_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         act_q  <= 1'b0;
         src_q  <= 1'b0;
         prio_q <= '0;
         tgt_q  <= '0;
         cfg_q  <= '0;
         pm_q   <= '0;
      end else begin
         src_q <= src_in;
         if (wr_set_en)      en_q <= 1'b1;
         else if (wr_clr_en) en_q <= 1'b0;
         if (wr_prio) prio_q <= wbyte;
         if (wr_tgt)  tgt_q  <= wbyte;
         if (wr_cfg)  cfg_q  <= src_cfg_t'(wcfg);
         pm_q <= (pm_q & ~pm_clr) | pm_set;
         if (ack_hit)      act_q <= 1'b1;
         else if (eoi_hit) act_q <= 1'b0;
      end
   end

   assign en      = en_q;
   assign active  = act_q;
   assign prio    = prio_q;
   assign tgt     = tgt_q;
   assign cfg     = cfg_q;
   assign pending = |pend_vec;
   assign fwd     = (en_q && !act_q) ? pend_vec : '0;

   // R3: a set-enable strobe leaves the source enabled
   a_r3_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set_en |=> en_q);
   // R10: acknowledge makes the source active
   a_r10_ack_active: assert property (@(posedge clk) disable iff (!rst_n)
      ack_hit |=> act_q);
   // R10: one-of-N acknowledge with no new event leaves nothing pending
   a_r10_one_n_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit && cfg_q.one_of_n && !wr_set_pd && !edge_evt && !sgi_hit) |=> (pm_q == '0));
   // R11: end of interrupt clears active
   a_r11_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_hit && !ack_hit) |=> !act_q);
   // R8: a level source with low input and no stored state is not pending
   a_r8_level_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_q.edge_trig && !src_in && pm_q == '0) |-> !pending);
endmodule

// File: rtl/idist_fwd.sv
module idist_fwd #(
   parameter int NUM_SRC = 32,
   parameter int NUM_CPU = 8,
   localparam int FLAT_W = NUM_SRC * NUM_CPU
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dist_en,
   input  logic [FLAT_W-1:0]  fwd_flat,
   output logic [NUM_CPU-1:0] cpu_irq
);
   logic [NUM_CPU-1:0] any_req;

   always_comb begin
      any_req = '0;
      for (int s = 0; s < NUM_SRC; s++) any_req |= fwd_flat[s*NUM_CPU +: NUM_CPU];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cpu_irq <= '0;
      else        cpu_irq <= dist_en ? any_req : '0;
   end

   // R2: gate closed means no request on the next cycle
   a_r2_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
      !dist_en |=> (cpu_irq == '0));
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
   import idist_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int NUM_CPU = 8,
   parameter int ADDR_W  = 7,
   localparam int CPU_W  = $clog2(NUM_CPU),
   localparam int SRC_W  = $clog2(NUM_SRC),
   localparam int N_W32  = NUM_SRC / 32,
   localparam int N_W4   = NUM_SRC / 4,
   localparam int N_W16  = NUM_SRC / 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wen,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic [NUM_SRC-1:0] src_in,
   input  logic [CPU_W-1:0]   sgi_req_cpu,
   input  logic               ack_valid,
   input  logic [CPU_W-1:0]   ack_cpu,
   input  logic [SRC_W-1:0]   ack_id,
   input  logic               eoi_valid,
   input  logic [SRC_W-1:0]   eoi_id,
   output logic [NUM_CPU-1:0] cpu_irq
);
   localparam logic [31:0] INFO_WORD = 32'(((NUM_CPU - 1) << 5) | (N_W32 - 1));

   if (NUM_SRC % 32 != 0 || NUM_SRC < 32 || NUM_SRC > 128) begin : g_bad_src
      $error("NUM_SRC must be 32, 64, 96 or 128");
   end
   if (NUM_CPU < 2 || NUM_CPU > TGT_W) begin : g_bad_cpu
      $error("NUM_CPU must be 2 to 8");
   end
   if (ADDR_W < MIN_AW) begin : g_bad_aw
      $error("ADDR_W too small for the register map");
   end

   logic                             dist_en_q;
   logic [NUM_SRC-1:0]               en_v, pend_v, act_v;
   logic [NUM_SRC-1:0][PRIO_W-1:0]   prio_a;
   logic [NUM_SRC-1:0][TGT_W-1:0]    tgt_a;
   src_cfg_t [NUM_SRC-1:0]           cfg_a;
   logic [NUM_SRC-1:0][1:0]          st_a;
   logic [NUM_SRC*NUM_CPU-1:0]       fwd_flat;
   logic                             sgi_wr;
   logic [3:0]                       sgi_id;
   logic [NUM_CPU-1:0]               sgi_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dist_en_q <= 1'b0;
      else if (bus_wen && bus_addr == ADDR_W'(A_CTRL)) dist_en_q <= bus_wdata[0];
   end

   assign sgi_wr = bus_wen && (bus_addr == ADDR_W'(A_SGI));
   assign sgi_id = bus_wdata[3:0];

   idist_sgi_resolve #(.NUM_CPU(NUM_CPU)) u_sgi (
      .clk     (clk),
      .rst_n   (rst_n),
      .list    (bus_wdata[16 +: NUM_CPU]),
      .filter  (bus_wdata[25:24]),
      .req_cpu (sgi_req_cpu),
      .mask    (sgi_mask)
   );

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      localparam int W32 = s / 32;
      localparam int B32 = s % 32;
      localparam int W4  = s / 4;
      localparam int B4  = s % 4;
      localparam int W16 = s / 16;
      localparam int B16 = s % 16;
      logic set_en_w, clr_en_w, set_pd_w, clr_pd_w, prio_w, tgt_w, cfg_w;
      logic sgi_hit, ack_hit, eoi_hit;

      assign set_en_w = bus_wen && bus_addr == ADDR_W'(A_SETEN + W32) && bus_wdata[B32];
      assign clr_en_w = bus_wen && bus_addr == ADDR_W'(A_CLREN + W32) && bus_wdata[B32];
      assign set_pd_w = bus_wen && bus_addr == ADDR_W'(A_SETPD + W32) && bus_wdata[B32];
      assign clr_pd_w = bus_wen && bus_addr == ADDR_W'(A_CLRPD + W32) && bus_wdata[B32];
      assign prio_w   = bus_wen && bus_addr == ADDR_W'(A_PRIO + W4);
      assign tgt_w    = bus_wen && bus_addr == ADDR_W'(A_TGT + W4);
      assign cfg_w    = bus_wen && bus_addr == ADDR_W'(A_CFG + W16);
      assign sgi_hit  = (s < SGI_IDS) && sgi_wr && (int'(sgi_id) == s);
      assign ack_hit  = ack_valid && (ack_id == SRC_W'(s));
      assign eoi_hit  = eoi_valid && (eoi_id == SRC_W'(s));

      idist_src_cell #(.NUM_CPU(NUM_CPU)) u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .src_in    (src_in[s]),
         .wr_set_en (set_en_w),
         .wr_clr_en (clr_en_w),
         .wr_set_pd (set_pd_w),
         .wr_clr_pd (clr_pd_w),
         .wr_prio   (prio_w),
         .wr_tgt    (tgt_w),
         .wr_cfg    (cfg_w),
         .wbyte     (bus_wdata[8*B4 +: 8]),
         .wcfg      (bus_wdata[2*B16 +: 2]),
         .sgi_hit   (sgi_hit),
         .sgi_mask  (sgi_mask),
         .ack_hit   (ack_hit),
         .ack_cpu   (ack_cpu),
         .eoi_hit   (eoi_hit),
         .en        (en_v[s]),
         .pending   (pend_v[s]),
         .active    (act_v[s]),
         .prio      (prio_a[s]),
         .tgt       (tgt_a[s]),
         .cfg       (cfg_a[s]),
         .fwd       (fwd_flat[s*NUM_CPU +: NUM_CPU])
      );

      assign st_a[s] = {act_v[s], pend_v[s]};
   end

   idist_fwd #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_fwd (
      .clk      (clk),
      .rst_n    (rst_n),
      .dist_en  (dist_en_q),
      .fwd_flat (fwd_flat),
      .cpu_irq  (cpu_irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(A_CTRL)) bus_rdata[0] = dist_en_q;
      if (bus_addr == ADDR_W'(A_INFO)) bus_rdata = INFO_WORD;
      for (int w = 0; w < N_W32; w++) begin
         if (bus_addr == ADDR_W'(A_SETEN + w) || bus_addr == ADDR_W'(A_CLREN + w))
            bus_rdata = en_v[32*w +: 32];
         if (bus_addr == ADDR_W'(A_SETPD + w) || bus_addr == ADDR_W'(A_CLRPD + w))
            bus_rdata = pend_v[32*w +: 32];
         if (bus_addr == ADDR_W'(A_ACT + w))
            bus_rdata = act_v[32*w +: 32];
      end
      for (int w = 0; w < N_W4; w++) begin
         if (bus_addr == ADDR_W'(A_PRIO + w)) bus_rdata = prio_a[4*w +: 4];
         if (bus_addr == ADDR_W'(A_TGT + w))  bus_rdata = tgt_a[4*w +: 4];
      end
      for (int w = 0; w < N_W16; w++) begin
         if (bus_addr == ADDR_W'(A_CFG + w))   bus_rdata = cfg_a[16*w +: 16];
         if (bus_addr == ADDR_W'(A_STATE + w)) bus_rdata = st_a[16*w +: 16];
      end
   end

   // R9: a request never appears while the gate was closed the cycle before
   a_r9_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_irq != '0) |-> $past(dist_en_q));
endmodule

// File: tb/tb_irq_distributor.sv
module tb_irq_distributor;
   localparam int NSRC = 32;
   localparam int NCPU = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  bus_addr = '0;
   logic        bus_wen = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NSRC-1:0] src_in = '0;
   logic [2:0]  sgi_req_cpu = '0;
   logic        ack_valid = 1'b0;
   logic [2:0]  ack_cpu = '0;
   logic [4:0]  ack_id = '0;
   logic        eoi_valid = 1'b0;
   logic [4:0]  eoi_id = '0;
   logic [NCPU-1:0] cpu_irq;

   int tests = 0;
   int fails = 0;

   always #10 clk = ~clk;

   irq_distributor #(.NUM_SRC(NSRC), .NUM_CPU(NCPU), .ADDR_W(7)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
      .sgi_req_cpu(sgi_req_cpu), .ack_valid(ack_valid), .ack_cpu(ack_cpu),
      .ack_id(ack_id), .eoi_valid(eoi_valid), .eoi_id(eoi_id), .cpu_irq(cpu_irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0;
   endtask

   task automatic rd(input logic [6:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic ack(input logic [2:0] c, input logic [4:0] id);
      @(negedge clk);
      ack_valid = 1'b1; ack_cpu = c; ack_id = id;
      @(negedge clk);
      ack_valid = 1'b0;
   endtask

   task automatic eoi(input logic [4:0] id);
      @(negedge clk);
      eoi_valid = 1'b1; eoi_id = id;
      @(negedge clk);
      eoi_valid = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(7'h00, d); chk("R1 gate", d, 0);
      rd(7'h04, d); chk("R1 enables", d, 0);
      rd(7'h0C, d); chk("R1 pending", d, 0);
      rd(7'h21, d); chk("R1 priority", d, 0);
      rd(7'h68, d); chk("R1 state", d, 0);
      chk("R1 cpu_irq", 32'(cpu_irq), 0);
      rd(7'h01, d); chk("R14 info", d, 32'h0000_00E0);
   endtask

   task automatic t_enable();
      logic [31:0] d;
      wr(7'h04, 32'h0000_00F0);
      rd(7'h04, d); chk("R3 set read", d, 32'hF0);
      rd(7'h08, d); chk("R3 clear-word read", d, 32'hF0);
      wr(7'h08, 32'h0000_0010);
      rd(7'h04, d); chk("R3 clear one", d, 32'hE0);
      wr(7'h04, 32'h0);
      wr(7'h08, 32'h0);
      rd(7'h04, d); chk("R3 zero write no effect", d, 32'hE0);
   endtask

   task automatic t_fields();
      logic [31:0] d;
      wr(7'h21, 32'h4433_2211);
      rd(7'h21, d); chk("R5 priority", d, 32'h4433_2211);
      wr(7'h41, 32'h0804_0201);
      rd(7'h41, d); chk("R5 target", d, 32'h0804_0201);
   endtask

   task automatic t_pending_gate();
      logic [31:0] d;
      wr(7'h0C, 32'h20);
      rd(7'h10, d); chk("R4 set pending", d, 32'h20);
      tick(); chk("R2 gate closed", 32'(cpu_irq), 0);
      wr(7'h00, 32'h1);
      rd(7'h00, d); chk("R2 gate read", d, 1);
      tick(); chk("R9 forward src5 cpu1", 32'(cpu_irq), 32'h02);
      wr(7'h10, 32'h20);
      rd(7'h0C, d); chk("R4 clear pending", d, 0);
      tick(); chk("R9 drop after clear", 32'(cpu_irq), 0);
      wr(7'h0C, 32'h10);
      rd(7'h0C, d); chk("R4 disabled src pending", d, 32'h10);
      tick(); tick(); chk("R9 disabled src held back", 32'(cpu_irq), 0);
      wr(7'h10, 32'h10);
   endtask

   task automatic t_edge();
      logic [31:0] d;
      wr(7'h60, 32'h0000_3000);
      rd(7'h60, d); chk("R6 config read", d, 32'h3000);
      @(negedge clk); src_in[6] = 1'b1;
      tick();
      rd(7'h0C, d); chk("R7 rising edge pends", d, 32'h40);
      chk("R9 edge forwarded cpu2", 32'(cpu_irq), 32'h04);
      wr(7'h10, 32'h40);
      tick(); tick();
      rd(7'h0C, d); chk("R7 held high no repend", d, 0);
      chk("R7 no request", 32'(cpu_irq), 0);
   endtask

   task automatic t_ack();
      logic [31:0] d;
      wr(7'h41, 32'h080C_0201);
      @(negedge clk); src_in[6] = 1'b0;
      @(negedge clk); src_in[6] = 1'b1;
      tick();
      rd(7'h68, d); chk("R12 code pending", d, 32'h1000);
      chk("R9 two cpus", 32'(cpu_irq), 32'h0C);
      ack(3'd2, 5'd6);
      rd(7'h68, d); chk("R10 one-of-N ack", d, 32'h2000);
      tick(); chk("R10 masked while active", 32'(cpu_irq), 0);
      @(negedge clk); src_in[6] = 1'b0;
      @(negedge clk); src_in[6] = 1'b1;
      tick();
      rd(7'h68, d); chk("R12 code pending+active", d, 32'h3000);
      chk("R10 still masked", 32'(cpu_irq), 0);
      eoi(5'd6);
      rd(7'h68, d); chk("R11 eoi clears active", d, 32'h1000);
      tick(); chk("R11 reforward", 32'(cpu_irq), 32'h0C);
      wr(7'h60, 32'h0000_2000);
      ack(3'd2, 5'd6);
      rd(7'h68, d); chk("R10 per-cpu ack state", d, 32'h3000);
      eoi(5'd6);
      tick(); chk("R10 per-cpu leaves cpu3", 32'(cpu_irq), 32'h08);
      wr(7'h10, 32'h40);
      @(negedge clk); src_in[6] = 1'b0;
      tick();
   endtask

   task automatic t_level();
      logic [31:0] d;
      @(negedge clk); src_in[7] = 1'b1;
      tick();
      rd(7'h0C, d); chk("R8 level high pends", d, 32'h80);
      chk("R8 forward cpu3", 32'(cpu_irq), 32'h08);
      ack(3'd3, 5'd7);
      rd(7'h68, d); chk("R8 active hides level", d, 32'h8000);
      @(negedge clk); src_in[7] = 1'b0;
      eoi(5'd7);
      rd(7'h68, d); chk("R11 level idle", d, 0);
      @(negedge clk); src_in[7] = 1'b1;
      @(negedge clk); src_in[7] = 1'b0;
      tick();
      rd(7'h0C, d); chk("R8 falls clears", d, 0);
   endtask

   task automatic t_sgi();
      logic [31:0] d;
      sgi_req_cpu = 3'd1;
      wr(7'h04, 32'h08);
      wr(7'h18, 32'h0005_0003);
      rd(7'h0C, d); chk("R13 list pends", d, 32'h08);
      chk("R13 list cpus", 32'(cpu_irq), 32'h05);
      wr(7'h10, 32'h08);
      wr(7'h18, 32'h0100_0003);
      tick(); chk("R13 all but requester", 32'(cpu_irq), 32'hFD);
      wr(7'h10, 32'h08);
      wr(7'h18, 32'h0200_0003);
      tick(); chk("R13 requester only", 32'(cpu_irq), 32'h02);
      wr(7'h10, 32'h08);
      wr(7'h18, 32'h03FF_0003);
      rd(7'h0C, d); chk("R13 none filter", d, 0);
      tick(); chk("R13 none no irq", 32'(cpu_irq), 0);
   endtask

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_enable();
      t_fields();
      t_pending_gate();
      t_edge();
      t_ack();
      t_level();
      t_sgi();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule